// File: doc/BRIEF.md
# Asynchronous MRAM Host Bus Controller

This block sits between a synchronous host and an asynchronous, SRAM-style non-volatile memory built from four byte-wide dies. The host hands over one byte read or byte write at a time through a valid/ready request port. The controller turns each request into a correctly ordered sequence of enable, write-strobe and output-enable levels on the memory pins, and returns a single-cycle response that carries the read byte and an uncorrectable-error indication.

A 23-bit linear byte address is split into a 21-bit offset within a die and a 2-bit die selector. The selector goes through a fixed, non-monotonic die map. Every phase of a cycle is a parameter in clock counts, and a counter runs each phase down: read access, the high-impedance guard after the write strobe falls, the write data pulse, and idle turnaround. The shared data bus is exposed as separate output, output-enable and input pins so that an external pad buffer can drive it. The open-drain, active-low error line is sampled together with the read data.

Top module: `mram_bus_ctrl`

## Requirements
- R1: At most one bit of `memCeN` is low in any cycle.
- R2: While a die is enabled, `memAddr` equals bits [20:0] of the accepted request address and stays stable.
- R3: Request address bits [22:21] select the enabled die: 00 drives `memCeN[0]` low, 01 drives `memCeN[1]` low, 10 drives `memCeN[3]` low and 11 drives `memCeN[2]` low.
- R4: A read holds `memWeN` high and keeps `memOeN` and the chosen enable low for exactly ACC_CYC cycles. The data bus is never driven during a read. `memDqIn` is captured in the last access cycle and returned on `rspRdata` with `rspValid` high for one cycle, in the cycle after the enable rises.
- R5: A write holds `memOeN` high throughout and keeps `memWeN` low for HIZ_CYC+WPW_CYC cycles. The chosen enable is low for those cycles plus one more, so the write ends when `memWeN` rises while the enable is still low. `rspValid` pulses once with `rspErr` at 0.
- R6: `memDqOe` rises only after `memWeN` has been low for HIZ_CYC cycles. It stays high for WPW_CYC+1 cycles, through the cycle in which `memWeN` rises. It is never high while `memOeN` is low.
- R7: `rspErr` on a read response is 1 when `memMbeN` was low in the last access cycle, and 0 otherwise.
- R8: After each cycle all enables are high, `memWeN` and `memOeN` are high and `memDqOe` is low for TURN_CYC cycles before `reqReady` returns high. This also spaces successive read addresses by at least ACC_CYC+TURN_CYC+1 cycles.
- R9: `reqReady` is high only while the controller is idle. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high.
- R10: While `rstN` is low, all enables, `memWeN` and `memOeN` are high, `memDqOe` and `rspValid` are low, and `reqReady` is high once `rstN` is released. An assertion of `rstN` in the middle of a cycle takes the memory pins to this state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = byte write, 0 = byte read |
| reqAddr | input | 23 | Linear byte address; [22:21] die selector, [20:0] offset |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Controller idle and accepting a request |
| rspValid | output | 1 | One-cycle response strobe |
| rspRdata | output | 8 | Read byte (0 on write responses) |
| rspErr | output | 1 | Uncorrectable error flagged during the read |
| memCeN | output | 4 | Active-low per-die enables |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memAddr | output | 21 | Offset within the die |
| memDqOut | output | 8 | Byte to drive onto the data bus |
| memDqOe | output | 1 | Drive enable for the data bus pad buffer |
| memDqIn | input | 8 | Byte sampled from the data bus |
| memMbeN | input | 1 | Active-low open-drain multi-bit error line |

## Verification
The assertions assume that the host keeps the request fields stable only on the edge of acceptance, and that `memDqIn` and `memMbeN` are settled by the last access cycle of a read. The bench memory model meets both by returning data and the error level combinationally whenever a read is open. It holds the error line high outside reads, and it changes request fields only on falling clock edges. Every bench transaction is a single accepted request, so the host never offers a second request during a cycle in progress.

// File: rtl/mram_ctrl_pkg.sv
package mram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WG,
    ST_WD,
    ST_WH,
    ST_TURN
  } phase_e;

  typedef struct packed {
    logic latchReq;
    logic ceOn;
    logic weOn;
    logic oeOn;
    logic dqDrive;
    logic captureRd;
    logic finishWr;
  } strobe_t;

  // linear selector -> physical die: 00->0, 01->1, 10->3, 11->2
  function automatic logic [1:0] mapDie(input logic [1:0] sel);
    return {sel[1], sel[1] ^ sel[0]};
  endfunction

endpackage

// File: rtl/mram_ctrl_fsm.sv
module mram_ctrl_fsm
  import mram_ctrl_pkg::*;
#(
  parameter int ACC_CYC  = 4,
  parameter int HIZ_CYC  = 2,
  parameter int WPW_CYC  = 3,
  parameter int TURN_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int MAX_AB = (ACC_CYC > HIZ_CYC) ? ACC_CYC : HIZ_CYC;
  localparam int MAX_CD = (WPW_CYC > TURN_CYC) ? WPW_CYC : TURN_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int WE_LOW = HIZ_CYC + WPW_CYC;
  localparam int RUN_W  = $clog2(WE_LOW + 2);

  phase_e state;
  logic [CNT_W-1:0] cnt;
  logic cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= reqWrite ? ST_WG : ST_RD;
          cnt   <= reqWrite ? CNT_W'(HIZ_CYC - 1) : CNT_W'(ACC_CYC - 1);
        end
        ST_RD: if (cntDone) begin
          state <= ST_TURN;
          cnt   <= CNT_W'(TURN_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_WG: if (cntDone) begin
          state <= ST_WD;
          cnt   <= CNT_W'(WPW_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_WD: if (cntDone) state <= ST_WH;
               else cnt <= cnt - 1'b1;
        ST_WH: begin
          state <= ST_TURN;
          cnt   <= CNT_W'(TURN_CYC - 1);
        end
        ST_TURN: if (cntDone) state <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.latchReq  = (state == ST_IDLE) && reqValid;
    stb.ceOn      = (state == ST_RD) || (state == ST_WG) ||
                    (state == ST_WD) || (state == ST_WH);
    stb.weOn      = (state == ST_WG) || (state == ST_WD);
    stb.oeOn      = (state == ST_RD);
    stb.dqDrive   = (state == ST_WD) || (state == ST_WH);
    stb.captureRd = (state == ST_RD) && cntDone;
    stb.finishWr  = (state == ST_WH);
  end

  assign reqReady = (state == ST_IDLE);

  // run length of the write strobe, used only by the checks below
  logic [RUN_W-1:0] weRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          weRun <= '0;
    else if (stb.weOn)  weRun <= weRun + 1'b1;
    else                weRun <= '0;
  end

  AST_DRIVE_AFTER_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.dqDrive) |-> (weRun == RUN_W'(HIZ_CYC)) && stb.weOn) // R6
    else $error("data driven before guard");

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.weOn) |-> (weRun == RUN_W'(WE_LOW)) && stb.ceOn) // R5
    else $error("write strobe width");

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !stb.ceOn && !stb.dqDrive) // R9
    else $error("ready while busy");

endmodule

// File: rtl/mram_ctrl_dp.sv
module mram_ctrl_dp
  import mram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int OFF_W  = 21,
  parameter int DATA_W = 8,
  parameter int DIES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  input  logic              memMbeN,
  output logic [DIES-1:0]   memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [OFF_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);

  localparam int SEL_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]  addrQ;
  logic [SEL_W-1:0]  dieQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dieQ  <= '0;
      dataQ <= '0;
    end else if (stb.latchReq) begin
      addrQ <= reqAddr[OFF_W-1:0];
      dieQ  <= mapDie(reqAddr[ADDR_W-1:OFF_W]);
      dataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= stb.captureRd || stb.finishWr;
      if (stb.captureRd) begin
        rspRdata <= memDqIn;
        rspErr   <= !memMbeN;
      end else if (stb.finishWr) begin
        rspRdata <= '0;
        rspErr   <= 1'b0;
      end
    end
  end

  for (genvar d = 0; d < DIES; d++) begin : g_ce
    assign memCeN[d] = !(stb.ceOn && (dieQ == SEL_W'(d)));
  end

  assign memWeN   = !stb.weOn;
  assign memOeN   = !stb.oeOn;
  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memDqOe  = stb.dqDrive;

  AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCeN)) // R1
    else $error("two enables low");

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!(&memCeN) && $past(!(&memCeN))) |-> $stable(memAddr)) // R2
    else $error("address moved in cycle");

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> memWeN && !(&memCeN)) // R4
    else $error("output enable outside read");

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !(&memCeN) && memOeN) // R5
    else $error("write strobe without enable");

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN) // R6
    else $error("bus contention");

endmodule

// File: rtl/mram_bus_ctrl.sv
module mram_bus_ctrl
  import mram_ctrl_pkg::*;
#(
  parameter int ACC_CYC  = 4,
  parameter int HIZ_CYC  = 2,
  parameter int WPW_CYC  = 3,
  parameter int TURN_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [22:0] reqAddr,
  input  logic [7:0]  reqWdata,
  output logic        reqReady,
  output logic        rspValid,
  output logic [7:0]  rspRdata,
  output logic        rspErr,
  output logic [3:0]  memCeN,
  output logic        memWeN,
  output logic        memOeN,
  output logic [20:0] memAddr,
  output logic [7:0]  memDqOut,
  output logic        memDqOe,
  input  logic [7:0]  memDqIn,
  input  logic        memMbeN
);

  strobe_t stb;

  mram_ctrl_fsm #(
    .ACC_CYC(ACC_CYC), .HIZ_CYC(HIZ_CYC),
    .WPW_CYC(WPW_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  mram_ctrl_dp #(
    .ADDR_W(23), .OFF_W(21), .DATA_W(8), .DIES(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .memMbeN(memMbeN), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (&memCeN) && memWeN && memOeN && !memDqOe) // R8
    else $error("pins active while idle");

  AST_RSP_OUTSIDE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady && (&memCeN)) // R4
    else $error("response timing");

endmodule

// File: tb/mram_bus_ctrl_bench.sv
module mram_bus_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACC  = 4;
  localparam int HIZ  = 2;
  localparam int WPW  = 3;
  localparam int TURN = 2;
  localparam int NVEC = 11;

  // {write, addr[22:0], data[7:0], injectErr}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 23'h000003, 8'hA5, 1'b0},
    {1'b1, 23'h200005, 8'h3C, 1'b0},
    {1'b1, 23'h400007, 8'h5A, 1'b0},
    {1'b1, 23'h600009, 8'hC3, 1'b0},
    {1'b0, 23'h000003, 8'h00, 1'b0},
    {1'b0, 23'h200005, 8'h00, 1'b1},
    {1'b0, 23'h400007, 8'h00, 1'b0},
    {1'b0, 23'h600009, 8'h00, 1'b1},
    {1'b1, 23'h1FFFF3, 8'h7E, 1'b0},
    {1'b0, 23'h000003, 8'h00, 1'b0},
    {1'b0, 23'h7FFFFF, 8'h00, 1'b1}
  };

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [22:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, rspValid, rspErr, memWeN, memOeN, memDqOe, memMbeN;
  logic [7:0] rspRdata, memDqOut, memDqIn;
  logic [3:0] memCeN;
  logic [20:0] memAddr;
  logic mbeInj = 0;

  int tests = 0, fails = 0;
  logic [7:0] devMem [64];
  logic [7:0] expMem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  mram_bus_ctrl u_mram_bus_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn), .memMbeN(memMbeN)
  );

  function automatic int ceIdx(input logic [3:0] ce);
    for (int i = 0; i < 4; i++) if (!ce[i]) return i;
    return 0;
  endfunction

  function automatic int expDie(input logic [1:0] sel);
    case (sel)
      2'b00: return 0;
      2'b01: return 1;
      2'b10: return 3;
      default: return 2;
    endcase
  endfunction

  // behavioural memory
  logic readOpen;
  assign readOpen = (memCeN != 4'hF) && !memOeN && memWeN;
  assign memDqIn  = readOpen ? devMem[{ceIdx(memCeN), memAddr[3:0]}] : 8'h00;
  assign memMbeN  = readOpen ? !mbeInj : 1'b1;
  always @(posedge memWeN)
    if (memCeN != 4'hF && memDqOe) devMem[{ceIdx(memCeN), memAddr[3:0]}] = memDqOut;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic wr, input logic [22:0] a, input logic [7:0] d,
                       input logic e);
    int ceCnt = 0, weCnt = 0, oeCnt = 0, dqCnt = 0, die = -1;
    int ohBad = 0, addrBad = 0, contBad = 0, guardBad = 0, tCnt = 0, tBad = 0, guard = 0;
    int key;
    logic [7:0] expRd;
    key = expDie(a[22:21]) * 16 + int'(a[3:0]);
    expRd = expMem[key];
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; mbeInj = e;
    @(negedge clk);
    reqValid = 0;
    while (!rspValid && guard < 100) begin
      if ($countones(~memCeN) > 1) ohBad++;
      if (memCeN != 4'hF) begin
        ceCnt++; die = ceIdx(memCeN);
        if (memAddr !== a[20:0]) addrBad++;
      end
      if (memDqOe && !memOeN) contBad++;
      if (memDqOe && weCnt < HIZ && !memWeN) guardBad++;
      if (memDqOe) dqCnt++;
      if (!memWeN) weCnt++;
      if (!memOeN) oeCnt++;
      guard++;
      @(negedge clk);
    end
    check("R3 die select", die, expDie(a[22:21]));
    check("R2 address", addrBad, 0);
    check("R1 one-hot enables", ohBad, 0);
    check("R6 no contention", contBad, 0);
    if (wr) begin
      check("R5 enable width", ceCnt, HIZ + WPW + 1);
      check("R5 strobe width", weCnt, HIZ + WPW);
      check("R5 oe held high", oeCnt, 0);
      check("R6 drive width", dqCnt, WPW + 1);
      check("R6 guard", guardBad, 0);
      check("R5 write err", rspErr, 0);
      expMem[key] = d;
    end else begin
      check("R4 access width", ceCnt, ACC);
      check("R4 oe width", oeCnt, ACC);
      check("R4 no strobe/drive", weCnt + dqCnt, 0);
      check("R4 read data", rspRdata, expRd);
      check("R7 error flag", rspErr, e);
    end
    while (!reqReady && tCnt < 100) begin
      if (memCeN != 4'hF || !memWeN || !memOeN || memDqOe) tBad++;
      tCnt++;
      @(negedge clk);
    end
    check("R8 turnaround length", tCnt, TURN);
    check("R8 pins quiet", tBad, 0);
    mbeInj = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin devMem[i] = 8'h00; expMem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check("R10 reset enables", memCeN, 4'hF);
    check("R10 reset strobes", {memWeN, memOeN, memDqOe, rspValid}, 4'b1100);
    rstN = 1;
    @(negedge clk);
    check("R9 ready after reset", reqReady, 1);

    for (int v = 0; v < NVEC; v++)
      runOp(VEC[v][32], VEC[v][31:9], VEC[v][8:1], VEC[v][0]);

    // R9: ready low during a cycle, request held does not restart it
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = 23'h200005;
    @(negedge clk);
    check("R9 busy not ready", reqReady, 0);
    reqAddr = 23'h600009;
    @(negedge clk);
    check("R2 address held while busy", memAddr, 21'h000005);
    reqValid = 0;
    while (!reqReady) @(negedge clk);

    // R10: reset in the middle of a write releases pins at once
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 23'h400001; reqWdata = 8'h99;
    @(negedge clk);
    reqValid = 0;
    @(negedge clk);
    #1 rstN = 0;
    #1;
    check("R10 mid-cycle reset pins", {memCeN, memWeN, memOeN, memDqOe}, 7'b1111110);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R10 ready after mid reset", reqReady, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule